// File: doc/BRIEF.md
# Four-lane single-precision compare and select unit

This unit handles one to four IEEE-754 single-precision lanes at a time. It covers the operations that need only comparison and sign handling, with no rounding: three-way compare, greater-or-equal set, less-than set, minimum, maximum, copy, absolute value, negation and two clamps. The three compares write floating-point constants into the result lanes, not booleans.

An operation is issued every cycle. It is given by a 9-bit major code and, for the unary group, by a 7-bit sub-code. Two size bits set how many lanes are active, and their count is `{hi,lo}+1`. The result and a per-lane mask are registered, so they appear one clock after issue. An inactive lane takes the destination input given in the same issue cycle, and its mask bit is clear.

Top module: `fp_cmp_sel_unit`

## Requirements
- R1: While `rst_n` is low, `result_o` is all zeros and `lane_mask_o` is 4'b0000.
- R2: For a recognised operation, the result and mask appear on the clock edge after issue. `lane_mask_o` has its low `{size_hi_i,size_lo_i}+1` bits set (00→0001, 01→0011, 10→0111, 11→1111). Lane i is bits [32i+31:32i].
- R3: Each lane whose mask bit is clear outputs the `dest_i` lane given in the same issue cycle.
- R4: Major code 011011101 (three-way compare) writes 0xBF800000 (-1.0) when a<b, 0x3F800000 (+1.0) when a>b, and 0x00000000 when a=b. +0 and -0 count as equal.
- R5: Code 011011110 writes 1.0 when a>=b and 0.0 otherwise. Code 011011111 writes 1.0 when a<b and 0.0 otherwise.
- R6: In any of the three compares, a lane with a NaN operand (exponent all ones, mantissa nonzero) gets 0x00000000.
- R7: Code 011011010 writes the lane minimum and code 011011011 writes the lane maximum, with ordering correct across signs.
- R8: When exactly one operand of a minimum or maximum is NaN, the other operand is the result.
- R9: Major code 110100000 with sub-code 0000000 copies a, 0000001 clears bit 31 of a, and 0000010 inverts bit 31 of a. Bits 30:0, NaN payloads included, are left unchanged.
- R10: Sub-code 0000100 clamps a to [0.0, 1.0]. A NaN input gives 0.0.
- R11: Sub-code 0000101 clamps a to [-1.0, 1.0]. A NaN input gives -1.0.
- R12: An unrecognised major code, or the unary major code with any other sub-code, gives mask 4'b0000 and `dest_i` on every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 9 | Major operation code |
| subop_i | input | 7 | Unary sub-code |
| size_hi_i | input | 1 | Size bit, set for 3 and 4 lanes |
| size_lo_i | input | 1 | Size bit, set for 2 and 4 lanes |
| src_a_i | input | 128 | First operand, four lanes |
| src_b_i | input | 128 | Second operand, four lanes |
| dest_i | input | 128 | Value passed through on inactive lanes |
| result_o | output | 128 | Registered result lanes |
| lane_mask_o | output | 4 | Registered per-lane valid mask |

## Verification
Lane computation and destination pass-through happen in the same cycle whenever the size is below four. The bench triggers this with sizes of one, two and three lanes, using destination patterns that cannot match any computed value. It then compares the whole 128-bit result against a value assembled by hand from both sources. Operations that combine NaN lanes with pass-through lanes show whether NaN handling stays confined to the active lanes.

// File: rtl/fp_cmp_sel_unit.sv
module fp_cmp_sel_unit #(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [8:0]            opcode_i,
  input  logic [6:0]            subop_i,
  input  logic                  size_hi_i,
  input  logic                  size_lo_i,
  input  logic [LANES*32-1:0]   src_a_i,
  input  logic [LANES*32-1:0]   src_b_i,
  input  logic [LANES*32-1:0]   dest_i,
  output logic [LANES*32-1:0]   result_o,
  output logic [LANES-1:0]      lane_mask_o
);
  localparam int VW = LANES * 32;

  localparam logic [8:0] OP_MIN   = 9'b011011010;
  localparam logic [8:0] OP_MAX   = 9'b011011011;
  localparam logic [8:0] OP_CMP3  = 9'b011011101;
  localparam logic [8:0] OP_SGE   = 9'b011011110;
  localparam logic [8:0] OP_SLT   = 9'b011011111;
  localparam logic [8:0] OP_UNARY = 9'b110100000;

  localparam logic [6:0] SUB_MOV   = 7'b0000000;
  localparam logic [6:0] SUB_ABS   = 7'b0000001;
  localparam logic [6:0] SUB_NEG   = 7'b0000010;
  localparam logic [6:0] SUB_SAT01 = 7'b0000100;
  localparam logic [6:0] SUB_SAT11 = 7'b0000101;

  localparam logic [31:0] F_ONE  = 32'h3F80_0000;
  localparam logic [31:0] F_MONE = 32'hBF80_0000;
  localparam logic [31:0] F_ZERO = 32'h0000_0000;

  function automatic logic is_nan(input logic [31:0] x);
    return (&x[30:23]) && (|x[22:0]);
  endfunction

  function automatic logic f_lt(input logic [31:0] a, input logic [31:0] b);
    if (is_nan(a) || is_nan(b)) return 1'b0;
    if (!(|a[30:0]) && !(|b[30:0])) return 1'b0;
    if (a[31] != b[31]) return a[31];
    if (a[31]) return a[30:0] > b[30:0];
    return a[30:0] < b[30:0];
  endfunction

  function automatic logic f_eq(input logic [31:0] a, input logic [31:0] b);
    if (is_nan(a) || is_nan(b)) return 1'b0;
    return !f_lt(a, b) && !f_lt(b, a);
  endfunction

  function automatic logic [31:0] f_min(input logic [31:0] a, input logic [31:0] b);
    if (is_nan(a)) return b;
    if (is_nan(b)) return a;
    return f_lt(b, a) ? b : a;
  endfunction

  function automatic logic [31:0] f_max(input logic [31:0] a, input logic [31:0] b);
    if (is_nan(a)) return b;
    if (is_nan(b)) return a;
    return f_lt(a, b) ? b : a;
  endfunction

  function automatic logic [31:0] lane_op(input logic [8:0] op, input logic [6:0] sub,
                                          input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    r = a;
    case (op)
      OP_MIN:  r = f_min(a, b);
      OP_MAX:  r = f_max(a, b);
      OP_CMP3: r = f_lt(a, b) ? F_MONE : (f_lt(b, a) ? F_ONE : F_ZERO);
      OP_SGE:  r = (f_lt(b, a) || f_eq(a, b)) ? F_ONE : F_ZERO;
      OP_SLT:  r = f_lt(a, b) ? F_ONE : F_ZERO;
      OP_UNARY: begin
        case (sub)
          SUB_ABS:   r = {1'b0, a[30:0]};
          SUB_NEG:   r = {~a[31], a[30:0]};
          SUB_SAT01: r = f_min(f_max(a, F_ZERO), F_ONE);
          SUB_SAT11: r = f_min(f_max(a, F_MONE), F_ONE);
          default:   r = a;
        endcase
      end
      default: r = a;
    endcase
    return r;
  endfunction

  logic            op_known;
  logic [2:0]      lane_cnt;
  logic [VW-1:0]   nxt_res;
  logic [LANES-1:0] nxt_mask;

  assign lane_cnt = {1'b0, size_hi_i, size_lo_i} + 3'd1;

  assign op_known = (opcode_i == OP_MIN) || (opcode_i == OP_MAX) ||
                    (opcode_i == OP_CMP3) || (opcode_i == OP_SGE) ||
                    (opcode_i == OP_SLT) ||
                    ((opcode_i == OP_UNARY) &&
                     ((subop_i == SUB_MOV) || (subop_i == SUB_ABS) ||
                      (subop_i == SUB_NEG) || (subop_i == SUB_SAT01) ||
                      (subop_i == SUB_SAT11)));

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      nxt_mask[i] = op_known && (i < int'(lane_cnt));
      nxt_res[32*i +: 32] = nxt_mask[i]
        ? lane_op(opcode_i, subop_i, src_a_i[32*i +: 32], src_b_i[32*i +: 32])
        : dest_i[32*i +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o    <= '0;
      lane_mask_o <= '0;
    end else begin
      result_o    <= nxt_res;
      lane_mask_o <= nxt_mask;
    end
  end
endmodule

// File: rtl/fp_cmp_sel_unit_chk.sv
module fp_cmp_sel_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [8:0]   opcode_i,
  input logic [6:0]   subop_i,
  input logic [127:0] src_a_i,
  input logic [127:0] dest_i,
  input logic [127:0] result_o,
  input logic [3:0]   lane_mask_o
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  always_comb begin
    if (rst_n === 1'b0)
      reset_clear_chk: assert (result_o == '0 && lane_mask_o == '0);
  end

  // R2
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_mask_o inside {4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111});

  // R12
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(opcode_i inside {9'b011011010, 9'b011011011, 9'b011011101,
                       9'b011011110, 9'b011011111, 9'b110100000})
    |=> lane_mask_o == 4'b0000);

  for (genvar g = 0; g < 4; g++) begin : g_lane
    // R3
    pass_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !lane_mask_o[g] |-> result_o[32*g +: 32] == $past(dest_i[32*g +: 32]));

    // R4
    cmp_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && lane_mask_o[g] && $past(opcode_i inside {9'b011011101, 9'b011011110, 9'b011011111})
      |-> result_o[32*g +: 32] inside {32'h3F80_0000, 32'hBF80_0000, 32'h0000_0000});

    // R9
    abs_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && lane_mask_o[g] && $past(opcode_i == 9'b110100000 && subop_i == 7'b0000001)
      |-> result_o[32*g +: 32] == {1'b0, $past(src_a_i[32*g +: 31])});

    // R9
    neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && lane_mask_o[g] && $past(opcode_i == 9'b110100000 && subop_i == 7'b0000010)
      |-> result_o[32*g +: 32] == {~$past(src_a_i[32*g+31]), $past(src_a_i[32*g +: 31])});
  end
endmodule

bind fp_cmp_sel_unit fp_cmp_sel_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .subop_i(subop_i),
  .src_a_i(src_a_i), .dest_i(dest_i), .result_o(result_o), .lane_mask_o(lane_mask_o)
);

// File: tb/fp_cmp_sel_unit_bench.sv
module fp_cmp_sel_unit_bench;
  localparam int CLK_PERIOD = 10;

  localparam logic [31:0] P1 = 32'h3F80_0000, N1 = 32'hBF80_0000;
  localparam logic [31:0] P2 = 32'h4000_0000, N2 = 32'hC000_0000;
  localparam logic [31:0] PH = 32'h3F00_0000, NH = 32'hBF00_0000;
  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] QN = 32'h7FC0_0000, SN = 32'hFFC0_0123;
  localparam logic [31:0] D0 = 32'hDEAD_0000, D1 = 32'hDEAD_0001;
  localparam logic [31:0] D2 = 32'hDEAD_0002, D3 = 32'hDEAD_0003;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [8:0]   opcode_i = '0;
  logic [6:0]   subop_i = '0;
  logic         size_hi_i = 1'b0, size_lo_i = 1'b0;
  logic [127:0] src_a_i = '0, src_b_i = '0, dest_i = '0;
  logic [127:0] result_o;
  logic [3:0]   lane_mask_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_cmp_sel_unit u_fp_cmp_sel_unit (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .subop_i(subop_i),
    .size_hi_i(size_hi_i), .size_lo_i(size_lo_i), .src_a_i(src_a_i),
    .src_b_i(src_b_i), .dest_i(dest_i), .result_o(result_o), .lane_mask_o(lane_mask_o)
  );

  function automatic logic [127:0] v4(input logic [31:0] l0, l1, l2, l3);
    return {l3, l2, l1, l0};
  endfunction

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [8:0] op, input logic [6:0] sub, input logic [1:0] sz,
                       input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    opcode_i = op; subop_i = sub; {size_hi_i, size_lo_i} = sz;
    src_a_i = a; src_b_i = b; dest_i = v4(D0, D1, D2, D3);
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 result", result_o, '0);
    chk("R1 mask", {124'd0, lane_mask_o}, '0);
  endtask

  task automatic t_cmp3();
    issue(9'b011011101, 7'd0, 2'b11, v4(P1, P2, N1, PZ), v4(P2, P1, N1, NZ));
    chk("R4 cmp3", result_o, v4(N1, P1, PZ, PZ));
    chk("R2 mask4", {124'd0, lane_mask_o}, 128'hF);
  endtask

  task automatic t_sge_slt();
    issue(9'b011011110, 7'd0, 2'b11, v4(P1, N2, PH, N1), v4(P1, N1, P2, N2));
    chk("R5 sge", result_o, v4(P1, PZ, PZ, P1));
    issue(9'b011011111, 7'd0, 2'b11, v4(P1, N2, PH, N1), v4(P1, N1, P2, N2));
    chk("R5 slt", result_o, v4(PZ, P1, P1, PZ));
  endtask

  task automatic t_nan_cmp();
    issue(9'b011011101, 7'd0, 2'b01, v4(QN, P1, P1, P1), v4(P1, QN, P2, P2));
    chk("R6 cmp3 nan / R3 pass", result_o, v4(PZ, PZ, D2, D3));
    chk("R2 mask2", {124'd0, lane_mask_o}, 128'h3);
    issue(9'b011011110, 7'd0, 2'b01, v4(QN, P1, P1, P1), v4(P1, QN, P2, P2));
    chk("R6 sge nan", result_o, v4(PZ, PZ, D2, D3));
    issue(9'b011011111, 7'd0, 2'b01, v4(QN, P1, P1, P1), v4(P1, QN, P2, P2));
    chk("R6 slt nan", result_o, v4(PZ, PZ, D2, D3));
  endtask

  task automatic t_minmax();
    issue(9'b011011010, 7'd0, 2'b11, v4(N2, P1, NH, P2), v4(N1, PH, PH, P1));
    chk("R7 min", result_o, v4(N2, PH, NH, P1));
    issue(9'b011011011, 7'd0, 2'b11, v4(N2, P1, NH, P2), v4(N1, PH, PH, P1));
    chk("R7 max", result_o, v4(N1, P1, PH, P2));
    issue(9'b011011010, 7'd0, 2'b01, v4(QN, P1, P1, P1), v4(P2, QN, P2, P2));
    chk("R8 min nan", result_o, v4(P2, P1, D2, D3));
    issue(9'b011011011, 7'd0, 2'b01, v4(QN, NH, P1, P1), v4(N2, QN, P2, P2));
    chk("R8 max nan", result_o, v4(N2, NH, D2, D3));
  endtask

  task automatic t_unary();
    issue(9'b110100000, 7'b0000000, 2'b11, v4(N2, SN, PZ, PH), '0);
    chk("R9 copy", result_o, v4(N2, SN, PZ, PH));
    issue(9'b110100000, 7'b0000001, 2'b11, v4(N2, SN, PZ, PH), '0);
    chk("R9 abs", result_o, v4(P2, 32'h7FC0_0123, PZ, PH));
    issue(9'b110100000, 7'b0000010, 2'b11, v4(N2, SN, PZ, PH), '0);
    chk("R9 neg", result_o, v4(P2, 32'h7FC0_0123, NZ, NH));
  endtask

  task automatic t_clamp();
    issue(9'b110100000, 7'b0000100, 2'b11, v4(P2, N1, PH, QN), '0);
    chk("R10 clamp01", result_o, v4(P1, PZ, PH, PZ));
    issue(9'b110100000, 7'b0000101, 2'b11, v4(P2, N2, NH, QN), '0);
    chk("R11 clamp11", result_o, v4(P1, N1, NH, N1));
  endtask

  task automatic t_sizes();
    issue(9'b011011101, 7'd0, 2'b00, v4(P1, P1, P1, P1), v4(P2, P2, P2, P2));
    chk("R2 size1 / R3", result_o, v4(N1, D1, D2, D3));
    chk("R2 mask1", {124'd0, lane_mask_o}, 128'h1);
    issue(9'b011011101, 7'd0, 2'b10, v4(P2, P2, P2, P2), v4(P1, P1, P1, P1));
    chk("R2 size3 / R3", result_o, v4(P1, P1, P1, D3));
    chk("R2 mask3", {124'd0, lane_mask_o}, 128'h7);
  endtask

  task automatic t_unknown();
    issue(9'b000000000, 7'd0, 2'b11, v4(P1, P1, P1, P1), v4(P2, P2, P2, P2));
    chk("R12 bad op", result_o, v4(D0, D1, D2, D3));
    chk("R12 bad op mask", {124'd0, lane_mask_o}, '0);
    issue(9'b110100000, 7'b0000011, 2'b11, v4(N2, N2, N2, N2), '0);
    chk("R12 bad sub", result_o, v4(D0, D1, D2, D3));
    chk("R12 bad sub mask", {124'd0, lane_mask_o}, '0);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_cmp3();
    t_sge_slt();
    t_nan_cmp();
    t_minmax();
    t_unary();
    t_clamp();
    t_sizes();
    t_unknown();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule